// File: doc/BRIEF.md
# Variable Memory Range Register Codec

This block converts a variable memory range between two forms. One form is a page-granular triple: a page base, a page count and an 8-bit memory type. The other is the pair of 64-bit words that a range register holds, a base word and a mask word. Pages are 4 KiB, so the address fields in both words begin at bit 12. The physical address width is a parameter.

The block has three independent paths, each with its own request, registered result and one-cycle valid strobe. The encode path builds a register pair from a triple. The decode path turns a register pair back into a triple. Decode treats an entry whose mask lacks its enable bit as free. It also repairs a mask whose upper bits are not a solid run of ones, and flags the repair. The compare path tells whether a stored pair differs from a pair read back from hardware, ignoring bits that carry no meaning. Each path is a single combinational stage followed by one register stage.

Top module: `vr_codec`

## Requirements
- R1: For a non-zero page count, the encoded base word holds the page base in bits [PHYS_W-1:12] and the type in bits [7:0], with all other bits zero.
- R2: For a non-zero page count, the encoded mask word holds the PW-bit two's complement of the page count in bits [PHYS_W-1:12] and sets bit 11 (the enable bit), with all other bits zero. PW is PHYS_W-12.
- R3: A page count of zero encodes both the base word and the mask word as all zeros, which leaves the range disabled.
- R4: On decode, a mask word with bit 11 clear yields page base, page count, type and the repair flag all zero.
- R5: On decode of an enabled entry, the page base is base word bits [PHYS_W-1:12] and the type is base word bits [7:0].
- R6: On decode of an enabled entry, the page count (PW+1 bits wide) is 2^PW minus the page mask used, where the page mask is mask word bits [PHYS_W-1:12] and bits above PHYS_W count as ones.
- R7: If the raw page mask is non-zero and some bit above its highest set bit is zero, decode sets every bit from the highest set bit upward. It uses that repaired mask for the count and raises the repair flag. Otherwise the flag is low.
- R8: Compare reports a base difference only in base word bits [PHYS_W-1:12] or [7:0]. It reports a mask difference only in mask word bits [PHYS_W-1:11]. Bits 11:8 of the base, bits 10:0 of the mask and all bits at or above PHYS_W are ignored.
- R9: Each valid output is high exactly in the cycle after its own request, and its results appear in that same cycle. The three paths do not affect one another.
- R10: During reset every output is zero.
- R11: A path's result outputs keep their last value while its request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_req | input | 1 | Start an encode this cycle |
| enc_page_base | input | PW | Range base in pages |
| enc_page_cnt | input | PW | Range size in pages, zero disables |
| enc_type | input | 8 | Memory type code |
| enc_vld | output | 1 | Encode result strobe |
| enc_base_word | output | REG_W | Encoded base word |
| enc_mask_word | output | REG_W | Encoded mask word |
| dec_req | input | 1 | Start a decode this cycle |
| dec_base_word | input | REG_W | Base word to decode |
| dec_mask_word | input | REG_W | Mask word to decode |
| dec_vld | output | 1 | Decode result strobe |
| dec_page_base | output | PW | Decoded base in pages |
| dec_page_cnt | output | PW+1 | Decoded size in pages |
| dec_type | output | 8 | Decoded memory type |
| dec_fixed | output | 1 | Mask needed repair |
| cmp_req | input | 1 | Start a compare this cycle |
| cmp_ref_base | input | REG_W | Stored base word |
| cmp_ref_mask | input | REG_W | Stored mask word |
| cmp_hw_base | input | REG_W | Base word read from hardware |
| cmp_hw_mask | input | REG_W | Mask word read from hardware |
| cmp_vld | output | 1 | Compare result strobe |
| cmp_base_diff | output | 1 | Meaningful base bits differ |
| cmp_mask_diff | output | 1 | Meaningful mask bits differ |

## Verification
Encode and decode can be requested in the same cycle, and decode can be handed a malformed mask while encode is turning a zero count into a cleared pair. The bench raises all three requests together on several directed cycles and on random cycles, and some of those cycles feed the freshly expected encode output straight back into decode. A behavioural model advances all three paths on every edge. Each output group is compared on every falling edge, so an interaction between paths or a missed hold shows up in the cycle where it happens.

// File: rtl/vr_codec_pkg.sv
package vr_codec_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int TYPE_W     = 8;
  localparam int EN_BIT     = 11;
  localparam int BASE_IGN_LO = 8;
  typedef logic [TYPE_W-1:0] mem_type_t;
endpackage

// File: rtl/vr_encode.sv
module vr_encode
  import vr_codec_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PHYS_W = 36,
  localparam int PW    = PHYS_W - PAGE_SHIFT
) (
  input  logic [PW-1:0]    page_base,
  input  logic [PW-1:0]    page_cnt,
  input  mem_type_t        mtype,
  output logic [REG_W-1:0] base_word,
  output logic [REG_W-1:0] mask_word
);
  logic [PW-1:0] neg_cnt;
  logic          cnt_nz;

  assign neg_cnt = PW'(~page_cnt + 1'b1);
  assign cnt_nz  = |page_cnt;

  always_comb begin
    base_word = '0;
    mask_word = '0;
    if (cnt_nz) begin
      base_word[PHYS_W-1:PAGE_SHIFT] = page_base;
      base_word[TYPE_W-1:0]          = mtype;
      mask_word[PHYS_W-1:PAGE_SHIFT] = neg_cnt;
      mask_word[EN_BIT]              = 1'b1;
    end
  end
endmodule

// File: rtl/vr_decode.sv
module vr_decode
  import vr_codec_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PHYS_W = 36,
  localparam int PW    = PHYS_W - PAGE_SHIFT
) (
  input  logic [REG_W-1:0] base_word,
  input  logic [REG_W-1:0] mask_word,
  output logic [PW-1:0]    page_base,
  output logic [PW:0]      page_cnt,
  output mem_type_t        mtype,
  output logic             fixed
);
  logic [PW-1:0] raw;
  logic [PW-1:0] above;
  logic [PW-1:0] ext;
  logic          raw_nz;
  logic          enabled;

  assign raw     = mask_word[PHYS_W-1:PAGE_SHIFT];
  assign raw_nz  = |raw;
  assign enabled = mask_word[EN_BIT];

  // above[i]: some raw bit strictly higher than i is set
  assign above[PW-1] = 1'b0;
  genvar gi;
  generate
    for (gi = PW - 2; gi >= 0; gi--) begin : g_above
      assign above[gi] = above[gi+1] | raw[gi+1];
    end
    for (gi = 0; gi < PW; gi++) begin : g_ext
      assign ext[gi] = raw[gi] | (raw_nz & ~above[gi]);
    end
  endgenerate

  always_comb begin
    page_base = '0;
    page_cnt  = '0;
    mtype     = '0;
    fixed     = 1'b0;
    if (enabled) begin
      page_base = base_word[PHYS_W-1:PAGE_SHIFT];
      mtype     = base_word[TYPE_W-1:0];
      // forced-ones above PHYS_W appear as the extra top bit
      page_cnt  = (PW+1)'(~{1'b1, ext} + 1'b1);
      fixed     = (ext != raw);
    end
  end
endmodule

// File: rtl/vr_compare.sv
module vr_compare
  import vr_codec_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PHYS_W = 36
) (
  input  logic [REG_W-1:0] ref_base,
  input  logic [REG_W-1:0] ref_mask,
  input  logic [REG_W-1:0] hw_base,
  input  logic [REG_W-1:0] hw_mask,
  output logic             base_diff,
  output logic             mask_diff
);
  logic [REG_W-1:0] base_care;
  logic [REG_W-1:0] mask_care;

  genvar gb;
  generate
    for (gb = 0; gb < REG_W; gb++) begin : g_care
      if (gb < PHYS_W && (gb < BASE_IGN_LO || gb >= PAGE_SHIFT)) begin : g_bc
        assign base_care[gb] = 1'b1;
      end else begin : g_bn
        assign base_care[gb] = 1'b0;
      end
      if (gb < PHYS_W && gb >= EN_BIT) begin : g_mc
        assign mask_care[gb] = 1'b1;
      end else begin : g_mn
        assign mask_care[gb] = 1'b0;
      end
    end
  endgenerate

  assign base_diff = |((ref_base ^ hw_base) & base_care);
  assign mask_diff = |((ref_mask ^ hw_mask) & mask_care);
endmodule

// File: rtl/vr_codec.sv
module vr_codec
  import vr_codec_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PHYS_W = 36,
  localparam int PW    = PHYS_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_req,
  input  logic [PW-1:0]    enc_page_base,
  input  logic [PW-1:0]    enc_page_cnt,
  input  logic [7:0]       enc_type,
  output logic             enc_vld,
  output logic [REG_W-1:0] enc_base_word,
  output logic [REG_W-1:0] enc_mask_word,
  input  logic             dec_req,
  input  logic [REG_W-1:0] dec_base_word,
  input  logic [REG_W-1:0] dec_mask_word,
  output logic             dec_vld,
  output logic [PW-1:0]    dec_page_base,
  output logic [PW:0]      dec_page_cnt,
  output logic [7:0]       dec_type,
  output logic             dec_fixed,
  input  logic             cmp_req,
  input  logic [REG_W-1:0] cmp_ref_base,
  input  logic [REG_W-1:0] cmp_ref_mask,
  input  logic [REG_W-1:0] cmp_hw_base,
  input  logic [REG_W-1:0] cmp_hw_mask,
  output logic             cmp_vld,
  output logic             cmp_base_diff,
  output logic             cmp_mask_diff
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // combinational paths
  logic [REG_W-1:0] enc_base_c, enc_mask_c;
  logic [PW-1:0]    dec_base_c;
  logic [PW:0]      dec_cnt_c;
  mem_type_t        dec_type_c;
  logic             dec_fixed_c;
  logic             cmp_bd_c, cmp_md_c;

  vr_encode #(.REG_W(REG_W), .PHYS_W(PHYS_W)) u_enc (
    .page_base(enc_page_base), .page_cnt(enc_page_cnt), .mtype(enc_type),
    .base_word(enc_base_c), .mask_word(enc_mask_c));

  vr_decode #(.REG_W(REG_W), .PHYS_W(PHYS_W)) u_dec (
    .base_word(dec_base_word), .mask_word(dec_mask_word),
    .page_base(dec_base_c), .page_cnt(dec_cnt_c), .mtype(dec_type_c),
    .fixed(dec_fixed_c));

  vr_compare #(.REG_W(REG_W), .PHYS_W(PHYS_W)) u_cmp (
    .ref_base(cmp_ref_base), .ref_mask(cmp_ref_mask),
    .hw_base(cmp_hw_base), .hw_mask(cmp_hw_mask),
    .base_diff(cmp_bd_c), .mask_diff(cmp_md_c));

  // next-state
  logic [REG_W-1:0] enc_base_d, enc_mask_d;
  logic [PW-1:0]    dec_base_d;
  logic [PW:0]      dec_cnt_d;
  logic [7:0]       dec_type_d;
  logic             dec_fixed_d, cmp_bd_d, cmp_md_d;

  always_comb begin
    enc_base_d  = enc_base_word;
    enc_mask_d  = enc_mask_word;
    dec_base_d  = dec_page_base;
    dec_cnt_d   = dec_page_cnt;
    dec_type_d  = dec_type;
    dec_fixed_d = dec_fixed;
    cmp_bd_d    = cmp_base_diff;
    cmp_md_d    = cmp_mask_diff;
    if (enc_req) begin
      enc_base_d = enc_base_c;
      enc_mask_d = enc_mask_c;
    end
    if (dec_req) begin
      dec_base_d  = dec_base_c;
      dec_cnt_d   = dec_cnt_c;
      dec_type_d  = dec_type_c;
      dec_fixed_d = dec_fixed_c;
    end
    if (cmp_req) begin
      cmp_bd_d = cmp_bd_c;
      cmp_md_d = cmp_md_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      enc_vld       <= 1'b0;
      enc_base_word <= '0;
      enc_mask_word <= '0;
      dec_vld       <= 1'b0;
      dec_page_base <= '0;
      dec_page_cnt  <= '0;
      dec_type      <= '0;
      dec_fixed     <= 1'b0;
      cmp_vld       <= 1'b0;
      cmp_base_diff <= 1'b0;
      cmp_mask_diff <= 1'b0;
    end else begin
      enc_vld       <= enc_req;
      enc_base_word <= enc_base_d;
      enc_mask_word <= enc_mask_d;
      dec_vld       <= dec_req;
      dec_page_base <= dec_base_d;
      dec_page_cnt  <= dec_cnt_d;
      dec_type      <= dec_type_d;
      dec_fixed     <= dec_fixed_d;
      cmp_vld       <= cmp_req;
      cmp_base_diff <= cmp_bd_d;
      cmp_mask_diff <= cmp_md_d;
    end
  end

  // assertions
  assert_enc_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    enc_req |=> enc_vld);
  assert_dec_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dec_req |=> !dec_vld);
  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enc_req && enc_page_cnt == '0) |=> (enc_mask_word == '0 && enc_base_word == '0));
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enc_req && enc_page_cnt != '0) |=> enc_mask_word[EN_BIT]);
  assert_free_entry_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_req && !dec_mask_word[EN_BIT]) |=> (dec_page_cnt == '0 && dec_type == '0 && !dec_fixed));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dec_req |=> $stable(dec_page_cnt));
  assert_same_pair_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_req && cmp_ref_base == cmp_hw_base && cmp_ref_mask == cmp_hw_mask)
      |=> (!cmp_base_diff && !cmp_mask_diff));
endmodule

// File: tb/sim_vr_codec.sv
`timescale 1ns/1ps
module sim_vr_codec;
  localparam int REG_W = 64;
  localparam int PHYS_W = 36;
  localparam int PW = PHYS_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic enc_req = 0, dec_req = 0, cmp_req = 0;
  logic [PW-1:0] enc_page_base = '0, enc_page_cnt = '0;
  logic [7:0] enc_type = '0;
  logic [REG_W-1:0] dec_base_word = '0, dec_mask_word = '0;
  logic [REG_W-1:0] cmp_ref_base = '0, cmp_ref_mask = '0, cmp_hw_base = '0, cmp_hw_mask = '0;
  logic enc_vld, dec_vld, cmp_vld, dec_fixed, cmp_base_diff, cmp_mask_diff;
  logic [REG_W-1:0] enc_base_word, enc_mask_word;
  logic [PW-1:0] dec_page_base;
  logic [PW:0] dec_page_cnt;
  logic [7:0] dec_type;

  vr_codec #(.REG_W(REG_W), .PHYS_W(PHYS_W)) u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] m_enc_base(logic [PW-1:0] pb, logic [PW-1:0] c, logic [7:0] t);
    if (c == 0) return 64'd0;
    return (64'(pb) << 12) | 64'(t);
  endfunction
  function automatic logic [63:0] m_enc_mask(logic [PW-1:0] c);
    longint unsigned neg;
    if (c == 0) return 64'd0;
    neg = ((64'd1 << PW) - 64'(c)) & ((64'd1 << PW) - 1);
    return (neg << 12) | 64'h800;
  endfunction
  function automatic void m_dec(input logic [63:0] bw, input logic [63:0] mw,
      output logic [PW-1:0] pb, output logic [PW:0] cnt, output logic [7:0] t, output logic fx);
    logic [PW-1:0] raw, ext;
    int h;
    pb = '0; cnt = '0; t = '0; fx = 0;
    if (!mw[11]) return;
    pb = bw[PHYS_W-1:12];
    t = bw[7:0];
    raw = mw[PHYS_W-1:12];
    h = -1;
    for (int i = 0; i < PW; i++) if (raw[i]) h = i;
    ext = raw;
    if (h >= 0) for (int i = h; i < PW; i++) ext[i] = 1'b1;
    fx = (ext != raw);
    cnt = (PW+1)'((64'd1 << PW) - 64'(ext));
  endfunction
  function automatic logic m_diff(logic [63:0] a, logic [63:0] b, bit is_mask);
    for (int i = 0; i < PHYS_W; i++) begin
      if (is_mask && i >= 11 && a[i] != b[i]) return 1;
      if (!is_mask && (i < 8 || i >= 12) && a[i] != b[i]) return 1;
    end
    return 0;
  endfunction

  logic e_ev, e_dv, e_cv, e_fx, e_bd, e_md;
  logic [63:0] e_eb, e_em;
  logic [PW-1:0] e_pb;
  logic [PW:0] e_cnt;
  logic [7:0] e_t;
  bit e_zero_cnt, e_free, e_hold_e, e_hold_d, in_reset;

  always @(posedge clk or negedge rst_n) begin
    logic [PW-1:0] pb; logic [PW:0] cn; logic [7:0] tt; logic fx;
    if (!rst_n) begin
      e_ev <= 0; e_dv <= 0; e_cv <= 0; e_fx <= 0; e_bd <= 0; e_md <= 0;
      e_eb <= 0; e_em <= 0; e_pb <= 0; e_cnt <= 0; e_t <= 0;
      e_zero_cnt <= 0; e_free <= 0; e_hold_e <= 0; e_hold_d <= 0;
    end else begin
      e_ev <= enc_req; e_dv <= dec_req; e_cv <= cmp_req;
      e_hold_e <= !enc_req; e_hold_d <= !dec_req;
      if (enc_req) begin
        e_eb <= m_enc_base(enc_page_base, enc_page_cnt, enc_type);
        e_em <= m_enc_mask(enc_page_cnt);
        e_zero_cnt <= (enc_page_cnt == 0);
      end
      if (dec_req) begin
        m_dec(dec_base_word, dec_mask_word, pb, cn, tt, fx);
        e_pb <= pb; e_cnt <= cn; e_t <= tt; e_fx <= fx;
        e_free <= !dec_mask_word[11];
      end
      if (cmp_req) begin
        e_bd <= m_diff(cmp_ref_base, cmp_hw_base, 0);
        e_md <= m_diff(cmp_ref_mask, cmp_hw_mask, 1);
      end
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    string te, tm, td, tc;
    if (!done) begin
      if (in_reset) begin
        te = "R10"; tm = "R10"; td = "R10"; tc = "R10";
      end else begin
        te = e_hold_e ? "R11" : "R1";
        tm = e_hold_e ? "R11" : (e_zero_cnt ? "R3" : "R2");
        td = e_hold_d ? "R11" : (e_free ? "R4" : "R5");
        tc = "R8";
      end
      chk(in_reset ? "R10" : "R9", {enc_vld, dec_vld, cmp_vld}, {e_ev, e_dv, e_cv}, "strobes");
      chk(te, enc_base_word, e_eb, "enc base word");
      chk(tm, enc_mask_word, e_em, "enc mask word");
      chk(td, {dec_page_base, dec_type}, {e_pb, e_t}, "dec base/type");
      chk(in_reset ? "R10" : (e_free ? "R4" : "R6"), dec_page_cnt, e_cnt, "dec page count");
      chk(in_reset ? "R10" : "R7", dec_fixed, e_fx, "dec repair flag");
      chk(tc, {cmp_base_diff, cmp_mask_diff}, {e_bd, e_md}, "cmp diffs");
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk); #1;
    enc_req = 0; dec_req = 0; cmp_req = 0;
  endtask
  task automatic do_enc(logic [PW-1:0] pb, logic [PW-1:0] c, logic [7:0] t);
    enc_page_base = pb; enc_page_cnt = c; enc_type = t; enc_req = 1;
  endtask
  task automatic do_dec(logic [63:0] bw, logic [63:0] mw);
    dec_base_word = bw; dec_mask_word = mw; dec_req = 1;
  endtask
  task automatic do_cmp(logic [63:0] rb, logic [63:0] rm, logic [63:0] hb, logic [63:0] hm);
    cmp_ref_base = rb; cmp_ref_mask = rm; cmp_hw_base = hb; cmp_hw_mask = hm; cmp_req = 1;
  endtask

  initial begin
    in_reset = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    #1 in_reset = 0;
    // R1 R2: 16-page range at page 0x100, type 6
    idle(); do_enc(24'h100, 24'h10, 8'h06);
    // R3: zero count clears pair, with decode of a free entry (R4) same cycle
    idle(); do_enc(24'h200, 24'h0, 8'h01); do_dec(64'hFFF_FFFF_FF06, 64'h0000_0000_0000_07FF);
    // R5 R6: well-formed mask, 16 pages
    idle(); do_dec(64'h0000_0001_0000_0F05, 64'h0000_000F_FFFF_0800);
    // R7: malformed mask 0x0000F0 pages (highest bit 7) -> repaired; enc + cmp same cycle
    idle(); do_dec(64'h0000_0000_1234_5004, 64'h0000_0000_000F_0800);
      do_enc(24'hFFFFFF, 24'h1, 8'hFF);
      do_cmp(64'h100006, 64'hFFFFF0800, 64'h100F06, 64'hFFFFF0FFF);
    // R7: mask with hole below top, e.g. 0xFF00F0 pages -> not repaired (top already solid)
    idle(); do_dec(64'h0000_0000_0000_0000, 64'h0000_000F_F00F_0800);
    // R6: enabled but zero page mask -> full 2^PW pages
    idle(); do_dec(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0800);
    // R8: differences in meaningful bits, and in ignored high bits
    idle(); do_cmp(64'h100006, 64'hFFFFF0800, 64'h100007, 64'hFFFFF0000);
    idle(); do_cmp(64'hF000_0000_0010_0006, 64'hFFFFF0800, 64'h0000_0000_0010_0006, 64'hFFFF_FFFF_FFFF_F800 & 64'hF_FFFF_F800 | 64'hFFF0_0000_0000_0000);
    // R11: idle cycles hold results
    idle(); idle(); idle();
    // round trip: encode then decode the expected pair, all three active
    for (int k = 0; k < 300; k++) begin
      logic [PW-1:0] pb, c;
      logic [7:0] t;
      logic [63:0] rb, rm;
      idle();
      pb = PW'($urandom); t = 8'($urandom);
      c = (k % 7 == 0) ? '0 : PW'(24'd1 << ($urandom % PW));
      if (k % 5 == 1) c = PW'($urandom);
      if ($urandom % 4 != 0) do_enc(pb, c, t);
      rb = m_enc_base(pb, c, t);
      rm = m_enc_mask(c);
      if (k % 3 == 0) rm = {$urandom, $urandom};
      if ($urandom % 4 != 0) do_dec(rb, rm);
      if ($urandom % 3 != 0)
        do_cmp(rb, rm, rb ^ (64'd1 << ($urandom % 64)), rm ^ (64'd1 << ($urandom % 64)));
    end
    idle(); idle(); idle();
    // R10: reset mid-run returns outputs to zero
    @(negedge clk); #1 rst_n = 0; in_reset = 1;
    @(negedge clk); @(negedge clk);
    #1 done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule